// File: doc/BRIEF.md
# Credit-Gated Message Transmit Port

This block is the send half of a processor core's attachment to an on-chip message network. Software first fills a small transmit buffer of up to four 64-bit payload words. It then issues a send command that carries a destination word. The destination word packs the target station number, an 8-bit software code and the message length.

Every send is gated by a credit counter that belongs to the addressed station. There are 128 counters, each programmed by software through a register/select index. When the counter is non-zero, the block takes one credit and streams a header plus the payload words onto a valid/ready output, one word per beat. When the counter is zero, nothing is sent and the block sets a sticky credit-failure flag in its status. The transmit buffer is left intact, so the same command can simply be issued again. Receivers hand credits back through a single-station return strobe.

Top module: `msg_tx_port`

## Requirements
- R1: After reset, `tx_status` is 0, `net_vld` is low and every credit counter reads 0.
- R2: A credit write with register index `cr_reg` and select `cr_sel` loads the counter of station `cr_reg*8 + cr_sel`. `cr_rdata` returns the counter addressed by the same pair, and no other counter changes.
- R3: A send issued while idle with a non-zero credit for station `snd_dest[6:0]` decrements that counter by one. From the next cycle, `tx_status[1]` (pending) is high and the output shows `net_stn = snd_dest[6:0]`, `net_code = snd_dest[15:8]` and `net_size = snd_dest[17:16]`.
- R4: A message of size field S is delivered as S+1 beats that carry buffer words 0..S in order. `net_last` is high only on the final beat, and a beat holds its data and header until `net_rdy` accepts it.
- R5: The pending bit stays high until the final beat is accepted and is low in the cycle that follows.
- R6: A send to a station whose credit is zero sends nothing and leaves the counter unchanged. It sets `tx_status[2]` (credit failure) and keeps the transmit buffer, so a retry after credits arrive delivers the original payload.
- R7: The credit-failure bit remains set across idle cycles and is cleared only by a send that succeeds.
- R8: A send issued while a message is pending is ignored: the output keeps its header and the addressed station's counter does not change.
- R9: A credit return (`crt_vld` with `crt_stn`) increments that station's counter by one and saturates at 255.
- R10: A credit return and a credit consumption on the same station in the same cycle leave its counter unchanged. A software write to a counter wins over both.
- R11: Writes to the transmit buffer while a message is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pl_we | input | 1 | Transmit buffer write strobe |
| pl_sel | input | 2 | Transmit buffer word select |
| pl_wdata | input | 64 | Transmit buffer write data |
| cr_we | input | 1 | Credit counter write strobe |
| cr_reg | input | 4 | Credit register index (station / 8) |
| cr_sel | input | 3 | Credit select (station % 8) |
| cr_wdata | input | 8 | Credit counter write value |
| cr_rdata | output | 8 | Counter addressed by cr_reg/cr_sel |
| snd_go | input | 1 | Send command strobe |
| snd_dest | input | 18 | Destination word: station [6:0], code [15:8], size-1 [17:16] |
| tx_status | output | 3 | Bit 2 credit failure (sticky), bit 1 pending, bit 0 reads 0 |
| crt_vld | input | 1 | Credit return strobe |
| crt_stn | input | 7 | Station receiving the returned credit |
| net_vld | output | 1 | Output beat valid |
| net_rdy | input | 1 | Output beat accepted |
| net_stn | output | 7 | Destination station of the message |
| net_code | output | 8 | Software code of the message |
| net_size | output | 2 | Message size minus one |
| net_data | output | 64 | Current payload word |
| net_last | output | 1 | Final beat of the message |

## Verification
The send path is tried with the following patterns, and each one separates a different fault:
- A four-word message held back by a stalled receiver shows whether beats advance without `net_rdy`.
- A single-word message checks that `net_last` marks the first beat.
- A send into an empty counter, followed by a retry once a credit has been written, shows whether a failure consumes credit or damages the buffer.
- A send and a buffer write made while a message is pending test the gating.
- Returning credits near the counter maximum checks saturation.
- A return in the same cycle as a consumption or a software write tests the counter update priority.

// File: rtl/msgtx_pkg.sv
package msgtx_pkg;
   localparam int DEST_W  = 18;
   localparam int STN_W   = 7;
   localparam int CODE_W  = 8;
   localparam int SIZE_W  = 2;

   typedef struct packed {
      logic [SIZE_W-1:0] size;
      logic [CODE_W-1:0] code;
      logic [STN_W-1:0]  stn;
   } dest_t;

   // Unpack the destination word; bits 7 is unused.
   function automatic dest_t unpack_dest(input logic [DEST_W-1:0] w);
      dest_t d;
      d.stn  = w[6:0];
      d.code = w[15:8];
      d.size = w[17:16];
      return d;
   endfunction
endpackage

// File: rtl/msgtx_payload_file.sv
module msgtx_payload_file #(
   parameter int WORD_W    = 64,
   parameter int MAX_WORDS = 4,
   localparam int WSEL_W   = $clog2(MAX_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WSEL_W-1:0] wsel,
   input  logic [WORD_W-1:0] wdata,
   input  logic [WSEL_W-1:0] rsel,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] word_w [MAX_WORDS];

   for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
      logic [WORD_W-1:0] w_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            w_q <= '0;
         else if (we && wsel == WSEL_W'(g))
            w_q <= wdata;
      end
      assign word_w[g] = w_q;
   end

   assign rdata = word_w[rsel];
endmodule

// File: rtl/msgtx_credit_bank.sv
module msgtx_credit_bank #(
   parameter int N_STN  = 128,
   parameter int CRED_W = 8,
   localparam int IDX_W = $clog2(N_STN),
   localparam logic [CRED_W-1:0] CMAX = {CRED_W{1'b1}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [CRED_W-1:0] wr_val,
   input  logic              dec_en,
   input  logic [IDX_W-1:0]  dec_idx,
   input  logic              ret_en,
   input  logic [IDX_W-1:0]  ret_idx,
   input  logic [IDX_W-1:0]  rd_idx_a,
   output logic [CRED_W-1:0] rd_val_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [CRED_W-1:0] rd_val_b
);
   logic [CRED_W-1:0] cnt_w [N_STN];

   for (genvar g = 0; g < N_STN; g++) begin : g_cnt
      logic [CRED_W-1:0] c_q;
      logic inc_req, dec_req;
      assign inc_req = ret_en && ret_idx == IDX_W'(g) && c_q != CMAX;
      assign dec_req = dec_en && dec_idx == IDX_W'(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            c_q <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))
            c_q <= wr_val;
         else if (inc_req && !dec_req)
            c_q <= c_q + 1'b1;
         else if (dec_req && !(ret_en && ret_idx == IDX_W'(g)))
            c_q <= c_q - 1'b1;
      end
      assign cnt_w[g] = c_q;
   end

   assign rd_val_a = cnt_w[rd_idx_a];
   assign rd_val_b = cnt_w[rd_idx_b];

   assert_dec_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dec_en |-> cnt_w[dec_idx] != '0);
   assert_wr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cnt_w[$past(wr_idx)] == $past(wr_val));
   assert_ret_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en && !wr_en && !dec_en && cnt_w[ret_idx] == CMAX)
      |=> cnt_w[$past(ret_idx)] == CMAX);
endmodule

// File: rtl/msgtx_beat_seq.sv
module msgtx_beat_seq #(
   parameter int MAX_WORDS = 4,
   localparam int WSEL_W   = $clog2(MAX_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WSEL_W-1:0] size_in,
   input  logic              rdy,
   output logic              busy,
   output logic [WSEL_W-1:0] beat,
   output logic              last
);
   logic              busy_q;
   logic [WSEL_W-1:0] beat_q, size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         beat_q <= '0;
         size_q <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            beat_q <= '0;
            size_q <= size_in;
         end
      end else if (rdy) begin
         if (beat_q == size_q)
            busy_q <= 1'b0;
         else
            beat_q <= beat_q + 1'b1;
      end
   end

   assign busy = busy_q;
   assign beat = beat_q;
   assign last = busy_q && beat_q == size_q;

   assert_pending_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !(rdy && last) |=> busy);
   assert_beat_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !rdy |=> $stable(beat));
endmodule

// File: rtl/msg_tx_port.sv
module msg_tx_port #(
   parameter int WORD_W      = 64,
   parameter int MAX_WORDS   = 4,
   parameter int N_STN       = 128,
   parameter int SEL_PER_REG = 8,
   parameter int CRED_W      = 8,
   localparam int WSEL_W     = $clog2(MAX_WORDS),
   localparam int IDX_W      = $clog2(N_STN),
   localparam int SEL_W      = $clog2(SEL_PER_REG),
   localparam int REG_W      = IDX_W - SEL_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pl_we,
   input  logic [WSEL_W-1:0]           pl_sel,
   input  logic [WORD_W-1:0]           pl_wdata,
   input  logic                        cr_we,
   input  logic [REG_W-1:0]            cr_reg,
   input  logic [SEL_W-1:0]            cr_sel,
   input  logic [CRED_W-1:0]           cr_wdata,
   output logic [CRED_W-1:0]           cr_rdata,
   input  logic                        snd_go,
   input  logic [msgtx_pkg::DEST_W-1:0] snd_dest,
   output logic [2:0]                  tx_status,
   input  logic                        crt_vld,
   input  logic [msgtx_pkg::STN_W-1:0] crt_stn,
   output logic                        net_vld,
   input  logic                        net_rdy,
   output logic [msgtx_pkg::STN_W-1:0] net_stn,
   output logic [msgtx_pkg::CODE_W-1:0] net_code,
   output logic [msgtx_pkg::SIZE_W-1:0] net_size,
   output logic [WORD_W-1:0]           net_data,
   output logic                        net_last
);
   import msgtx_pkg::*;

   initial begin
      assert (MAX_WORDS == (1 << SIZE_W)) else $fatal(1, "MAX_WORDS must match size field");
      assert (N_STN <= (1 << STN_W)) else $fatal(1, "N_STN exceeds station field");
      assert (N_STN % SEL_PER_REG == 0) else $fatal(1, "N_STN must be a multiple of SEL_PER_REG");
   end

   dest_t             req_d, dest_q;
   logic              busy, fail_q, go_ok, go_fail;
   logic [CRED_W-1:0] req_cred;
   logic [WSEL_W-1:0] beat;
   logic [IDX_W-1:0]  cr_idx;

   assign req_d  = unpack_dest(snd_dest);
   assign cr_idx = {cr_reg, cr_sel};

   assign go_ok   = snd_go && !busy && req_cred != '0;
   assign go_fail = snd_go && !busy && req_cred == '0;

   msgtx_credit_bank #(.N_STN(N_STN), .CRED_W(CRED_W)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cr_we), .wr_idx(cr_idx), .wr_val(cr_wdata),
      .dec_en(go_ok), .dec_idx(req_d.stn[IDX_W-1:0]),
      .ret_en(crt_vld), .ret_idx(crt_stn[IDX_W-1:0]),
      .rd_idx_a(req_d.stn[IDX_W-1:0]), .rd_val_a(req_cred),
      .rd_idx_b(cr_idx), .rd_val_b(cr_rdata));

   msgtx_payload_file #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) pay_i (
      .clk(clk), .rst_n(rst_n),
      .we(pl_we && !busy), .wsel(pl_sel), .wdata(pl_wdata),
      .rsel(beat), .rdata(net_data));

   msgtx_beat_seq #(.MAX_WORDS(MAX_WORDS)) seq_i (
      .clk(clk), .rst_n(rst_n),
      .start(go_ok), .size_in(req_d.size), .rdy(net_rdy),
      .busy(busy), .beat(beat), .last(net_last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dest_q <= '0;
         fail_q <= 1'b0;
      end else begin
         if (go_ok) begin
            dest_q <= req_d;
            fail_q <= 1'b0;
         end else if (go_fail) begin
            fail_q <= 1'b1;
         end
      end
   end

   assign net_vld   = busy;
   assign net_stn   = dest_q.stn;
   assign net_code  = dest_q.code;
   assign net_size  = dest_q.size;
   assign tx_status = {fail_q, busy, 1'b0};

   assert_fail_no_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
      go_fail |=> !net_vld && tx_status[2]);
   assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_status[2] && !snd_go |=> tx_status[2]);
   assert_hdr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      net_vld && !(net_rdy && net_last) |=> $stable(net_stn) && $stable(net_code) && $stable(net_size));
   assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      net_last |-> net_vld);
   assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      net_vld && !net_rdy |=> net_vld && $stable(net_data));
endmodule

// File: tb/msg_tx_port_tb_top.sv
module msg_tx_port_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pl_we = 1'b0;
   logic [1:0]  pl_sel = '0;
   logic [63:0] pl_wdata = '0;
   logic        cr_we = 1'b0;
   logic [3:0]  cr_reg = '0;
   logic [2:0]  cr_sel = '0;
   logic [7:0]  cr_wdata = '0;
   logic [7:0]  cr_rdata;
   logic        snd_go = 1'b0;
   logic [17:0] snd_dest = '0;
   logic [2:0]  tx_status;
   logic        crt_vld = 1'b0;
   logic [6:0]  crt_stn = '0;
   logic        net_vld, net_rdy = 1'b0, net_last;
   logic [6:0]  net_stn;
   logic [7:0]  net_code;
   logic [1:0]  net_size;
   logic [63:0] net_data;

   int errors = 0;
   int checks = 0;
   logic [63:0] exp_pl [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   msg_tx_port dut_i (
      .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_sel(pl_sel), .pl_wdata(pl_wdata),
      .cr_we(cr_we), .cr_reg(cr_reg), .cr_sel(cr_sel), .cr_wdata(cr_wdata),
      .cr_rdata(cr_rdata), .snd_go(snd_go), .snd_dest(snd_dest), .tx_status(tx_status),
      .crt_vld(crt_vld), .crt_stn(crt_stn), .net_vld(net_vld), .net_rdy(net_rdy),
      .net_stn(net_stn), .net_code(net_code), .net_size(net_size),
      .net_data(net_data), .net_last(net_last));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic rd_cred(input int stn, output logic [7:0] v);
      cr_reg = 4'(stn / 8);
      cr_sel = 3'(stn % 8);
      #1;
      v = cr_rdata;
   endtask

   task automatic wr_cred(input int stn, input logic [7:0] val);
      cr_we = 1'b1; cr_reg = 4'(stn / 8); cr_sel = 3'(stn % 8); cr_wdata = val;
      @(negedge clk);
      cr_we = 1'b0;
   endtask

   task automatic wr_pl(input int sel, input logic [63:0] d);
      pl_we = 1'b1; pl_sel = 2'(sel); pl_wdata = d;
      @(negedge clk);
      pl_we = 1'b0;
   endtask

   task automatic send(input logic [17:0] dest);
      snd_go = 1'b1; snd_dest = dest;
      @(negedge clk);
      snd_go = 1'b0;
   endtask

   function automatic logic [17:0] mk_dest(input int size1, input int code, input int stn);
      return {2'(size1), 8'(code), 1'b0, 7'(stn)};
   endfunction

   task automatic collect(input int nb, input string req);
      net_rdy = 1'b1;
      for (int b = 0; b < nb; b++) begin
         chk(net_vld == 1'b1, req, 64'(net_vld), 64'd1);
         chk(net_data == exp_pl[b], req, net_data, exp_pl[b]);
         chk(net_last == (b == nb - 1), req, 64'(net_last), 64'(b == nb - 1));
         @(negedge clk);
      end
      net_rdy = 1'b0;
      chk(tx_status[1] == 1'b0 && !net_vld, "R5", 64'(tx_status), 64'd0);
   endtask

   task automatic load_pl(input logic [63:0] base);
      for (int i = 0; i < 4; i++) begin
         exp_pl[i] = base + 64'(i) * 64'h1111;
         wr_pl(i, exp_pl[i]);
      end
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk(tx_status == 3'd0, "R1", 64'(tx_status), 64'd0);
      chk(net_vld == 1'b0, "R1", 64'(net_vld), 64'd0);
      rd_cred(0, v);   chk(v == 8'd0, "R1", 64'(v), 64'd0);
      rd_cred(77, v);  chk(v == 8'd0, "R1", 64'(v), 64'd0);
      rd_cred(127, v); chk(v == 8'd0, "R1", 64'(v), 64'd0);
   endtask

   task automatic t_prog();
      logic [7:0] v;
      wr_cred(9, 8'd5);
      wr_cred(127, 8'd200);
      rd_cred(9, v);   chk(v == 8'd5, "R2", 64'(v), 64'd5);
      rd_cred(127, v); chk(v == 8'd200, "R2", 64'(v), 64'd200);
      rd_cred(8, v);   chk(v == 8'd0, "R2", 64'(v), 64'd0);
      rd_cred(17, v);  chk(v == 8'd0, "R2", 64'(v), 64'd0);
   endtask

   task automatic t_send4();
      logic [7:0] v;
      load_pl(64'hA000_0000_0000_0001);
      send(mk_dest(3, 8'hA5, 9));
      chk(tx_status[1] == 1'b1, "R3", 64'(tx_status), 64'd2);
      chk(net_stn == 7'd9 && net_code == 8'hA5 && net_size == 2'd3, "R3",
          {41'd0, net_size, net_code, net_stn, 6'd0}, {41'd0, 2'd3, 8'hA5, 7'd9, 6'd0});
      rd_cred(9, v); chk(v == 8'd4, "R3", 64'(v), 64'd4);
      // stalled receiver: send to 127 and a buffer write must be ignored
      send(mk_dest(0, 8'h11, 127));
      wr_pl(0, 64'hDEAD);
      chk(net_stn == 7'd9 && net_code == 8'hA5, "R8", 64'(net_stn), 64'd9);
      rd_cred(127, v); chk(v == 8'd200, "R8", 64'(v), 64'd200);
      chk(net_data == exp_pl[0], "R4", net_data, exp_pl[0]);
      chk(net_data != 64'hDEAD, "R11", net_data, exp_pl[0]);
      collect(4, "R4");
   endtask

   task automatic t_fail();
      logic [7:0] v;
      load_pl(64'h5000_0000_0000_0007);
      send(mk_dest(1, 8'h3C, 20));
      chk(tx_status[2] == 1'b1 && !net_vld, "R6", 64'(tx_status), 64'd4);
      rd_cred(20, v); chk(v == 8'd0, "R6", 64'(v), 64'd0);
      repeat (3) @(negedge clk);
      chk(tx_status[2] == 1'b1, "R7", 64'(tx_status), 64'd4);
      wr_cred(20, 8'd1);
      send(mk_dest(1, 8'h3C, 20));
      chk(tx_status == 3'b010, "R7", 64'(tx_status), 64'd2);
      chk(net_stn == 7'd20, "R6", 64'(net_stn), 64'd20);
      collect(2, "R6");
      rd_cred(20, v); chk(v == 8'd0, "R3", 64'(v), 64'd0);
   endtask

   task automatic t_size1();
      wr_cred(50, 8'd1);
      exp_pl[0] = 64'hCAFE_F00D;
      wr_pl(0, exp_pl[0]);
      send(mk_dest(0, 8'h01, 50));
      chk(net_size == 2'd0 && net_last, "R4", 64'(net_last), 64'd1);
      collect(1, "R4");
   endtask

   task automatic t_ret();
      logic [7:0] v;
      wr_cred(30, 8'd2);
      crt_vld = 1'b1; crt_stn = 7'd30;
      @(negedge clk);
      crt_vld = 1'b0;
      rd_cred(30, v); chk(v == 8'd3, "R9", 64'(v), 64'd3);
      wr_cred(31, 8'd254);
      crt_vld = 1'b1; crt_stn = 7'd31;
      @(negedge clk);
      @(negedge clk);
      crt_vld = 1'b0;
      rd_cred(31, v); chk(v == 8'd255, "R9", 64'(v), 64'd255);
   endtask

   task automatic t_coll();
      logic [7:0] v;
      wr_cred(40, 8'd3);
      load_pl(64'h7700_0000_0000_0000);
      crt_vld = 1'b1; crt_stn = 7'd40;
      send(mk_dest(0, 8'h40, 40));
      crt_vld = 1'b0;
      rd_cred(40, v); chk(v == 8'd3, "R10", 64'(v), 64'd3);
      collect(1, "R10");
      crt_vld = 1'b1; crt_stn = 7'd41;
      wr_cred(41, 8'd9);
      crt_vld = 1'b0;
      rd_cred(41, v); chk(v == 8'd9, "R10", 64'(v), 64'd9);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prog();
      t_send4();
      t_fail();
      t_size1();
      t_ret();
      t_coll();
      summary();
   end
endmodule